// File: doc/BRIEF.md
# Evolvable 3x3 Processing-Element Image Filter

This block is a reconfigurable, feed-forward pixel filter. Nine 8-bit processing elements (PEs) sit in three columns of three. A genome of 4-bit genes sets each PE's two operand sources and its function, and one more gene picks which PE drives the filter result. Each PE has sixteen functions. Its operands come from the 3x3 pixel window or from the PEs of an earlier column, so the array has no loops.

A search engine outside the block loads a candidate genome one nibble per cycle and waits for the ready flag. It then presents pixel windows with a valid strobe. The array settles combinationally, and the chosen PE output is captured one cycle after each strobe. That result is compared with the target image to score the candidate.

Top module: `evo_filter3x3`

## Requirements
- R1: After reset, `chrom_ready`, `out_valid` and `out_pix` are 0. The stored genome is all zero, so every PE outputs 255 and PE0 drives the result.
- R2: Each cycle with `cfg_valid` high stores one nibble. Nibble 3p is PE p's operand-A select, 3p+1 its operand-B select and 3p+2 its function code, for p = 0..8. Nibble 27 is the output select. `chrom_ready` goes high in the cycle after the 28th nibble is taken, and changes only on cycles with `cfg_valid`.
- R3: A nibble accepted while `chrom_ready` is high starts a new load at nibble 0, and `chrom_ready` drops the next cycle.
- R4: Select values 0..8 take window pixel k, which sits in `win_pix[8k+7:8k]`. Pixel 0 is the centre.
- R5: PE p lies in column p/3. Select 9..11 takes PE0..PE2, and is legal for columns 1 and 2. Select 12..14 takes PE3..PE5, and is legal for column 2 only. Value 15, and any select that points to the PE's own column or a later one, takes pixel 0.
- R6: Single-operand functions act on A: 0 gives 255, 1 gives A, 2 gives 255-A, 8 gives A>>1, 9 gives A>>2, 10 swaps the two nibbles of A.
- R7: Logic functions: 3 gives A|B, 4 gives (~A)|B, 5 gives A&B, 6 gives ~(A&B), 7 gives A^B.
- R8: Arithmetic functions: 11 gives (A+B) mod 256, 12 gives A+B clamped at 255, 13 gives (A+B)>>1 with a 9-bit sum, 14 gives the unsigned maximum, 15 the unsigned minimum.
- R9: Output select 0..8 routes PE0..PE8 to the result. Values above 8 route PE8.
- R10: A `pix_valid` cycle loads `out_pix` at that edge, and `out_valid` is high for exactly the next cycle. Without `pix_valid`, `out_pix` holds even if the window changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Genome nibble strobe |
| cfg_nibble | input | 4 | Genome nibble |
| pix_valid | input | 1 | Window strobe |
| win_pix | input | 72 | Nine 8-bit pixels, pixel 0 (centre) in the low byte |
| chrom_ready | output | 1 | Full genome loaded |
| out_valid | output | 1 | Result valid |
| out_pix | output | 8 | Filtered pixel |

## Verification
The hardest case to reach from the ports is a cross-column route. A deep PE's operand comes from a specific earlier PE, and the legality mask has to reroute a backward or same-column select to the centre pixel. The bench builds genomes in which the upstream PEs pass distinct window pixels through, so every source has its own value. Each PE of interest is then made the output through the output select. All sixteen function codes are swept on operand pairs that reach the saturation, wrap and nibble-swap corners.

// File: rtl/evo_filter3x3.sv
module evo_filter3x3 #(
  parameter int PIX_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_valid,
  input  logic [3:0]         cfg_nibble,
  input  logic               pix_valid,
  input  logic [9*PIX_W-1:0] win_pix,
  output logic               chrom_ready,
  output logic               out_valid,
  output logic [PIX_W-1:0]   out_pix
);
  localparam int N_ROW = 3;
  localparam int N_COL = 3;
  localparam int N_PE  = N_ROW * N_COL;
  localparam int N_NIB = 3 * N_PE + 1;
  localparam int CNT_W = $clog2(N_NIB);
  localparam int HALF  = PIX_W / 2;
  localparam int BUS_W = N_ROW * PIX_W;

  typedef logic [PIX_W-1:0] pix_t;

  logic [3:0]       chrom [N_NIB];
  logic [CNT_W-1:0] nib_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_NIB; i++) chrom[i] <= '0;
      nib_cnt     <= '0;
      chrom_ready <= 1'b0;
    end else if (cfg_valid) begin
      chrom[nib_cnt] <= cfg_nibble;
      if (nib_cnt == CNT_W'(N_NIB - 1)) begin
        nib_cnt     <= '0;
        chrom_ready <= 1'b1;
      end else begin
        nib_cnt     <= nib_cnt + 1'b1;
        chrom_ready <= 1'b0;
      end
    end
  end

  function automatic pix_t pick(input logic [3:0] s, input int col,
                                input logic [9*PIX_W-1:0] w,
                                input logic [BUS_W-1:0] b0,
                                input logic [BUS_W-1:0] b1);
    int v;
    v = int'(s);
    if (v < 9) return w[v*PIX_W +: PIX_W];
    if (v < 12 && col >= 1) return b0[(v-9)*PIX_W +: PIX_W];
    if (v >= 12 && v < 15 && col >= 2) return b1[(v-12)*PIX_W +: PIX_W];
    return w[PIX_W-1:0];
  endfunction

  function automatic pix_t pe_op(input logic [3:0] op, input pix_t a, input pix_t b);
    logic [PIX_W:0] sum;
    sum = {1'b0, a} + {1'b0, b};
    case (op)
      4'd0:    return '1;
      4'd1:    return a;
      4'd2:    return ~a;
      4'd3:    return a | b;
      4'd4:    return ~a | b;
      4'd5:    return a & b;
      4'd6:    return ~(a & b);
      4'd7:    return a ^ b;
      4'd8:    return a >> 1;
      4'd9:    return a >> 2;
      4'd10:   return {a[HALF-1:0], a[PIX_W-1:HALF]};
      4'd11:   return sum[PIX_W-1:0];
      4'd12:   return sum[PIX_W] ? '1 : sum[PIX_W-1:0];
      4'd13:   return sum[PIX_W:1];
      4'd14:   return (a > b) ? a : b;
      default: return (a < b) ? a : b;
    endcase
  endfunction

  logic [BUS_W-1:0] c0_bus, c1_bus, c2_bus;

  for (genvar c = 0; c < N_COL; c++) begin : g_col
    for (genvar r = 0; r < N_ROW; r++) begin : g_pe
      localparam int P = c * N_ROW + r;
      logic [BUS_W-1:0] pb0, pb1;
      pix_t opa, opb, res;
      if (c == 0) begin : g_c0
        assign pb0 = '0;
        assign pb1 = '0;
        assign c0_bus[r*PIX_W +: PIX_W] = res;
      end else if (c == 1) begin : g_c1
        assign pb0 = c0_bus;
        assign pb1 = '0;
        assign c1_bus[r*PIX_W +: PIX_W] = res;
      end else begin : g_c2
        assign pb0 = c0_bus;
        assign pb1 = c1_bus;
        assign c2_bus[r*PIX_W +: PIX_W] = res;
      end
      assign opa = pick(chrom[3*P],   c, win_pix, pb0, pb1);
      assign opb = pick(chrom[3*P+1], c, win_pix, pb0, pb1);
      assign res = pe_op(chrom[3*P+2], opa, opb);
    end
  end

  logic [N_PE*PIX_W-1:0] all_bus;
  logic [3:0]            osel;
  pix_t                  sel_pix;

  assign all_bus = {c2_bus, c1_bus, c0_bus};
  assign osel    = (chrom[N_NIB-1] > 4'd8) ? 4'd8 : chrom[N_NIB-1];
  assign sel_pix = all_bus[int'(osel)*PIX_W +: PIX_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= pix_valid;
      if (pix_valid) out_pix <= sel_pix;
    end
  end
endmodule

module evo_filter3x3_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_valid,
  input logic             pix_valid,
  input logic             chrom_ready,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_pix
);
  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);
  assert_valid_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);
  assert_pix_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> $stable(out_pix));
  assert_ready_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chrom_ready) |-> $past(cfg_valid));
  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |=> $stable(chrom_ready));
  assert_reload_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && chrom_ready) |=> !chrom_ready);
endmodule

bind evo_filter3x3 evo_filter3x3_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .pix_valid(pix_valid),
  .chrom_ready(chrom_ready), .out_valid(out_valid), .out_pix(out_pix)
);

// File: tb/sim_evo_filter3x3.sv
module sim_evo_filter3x3;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [3:0]  cfg_nibble = '0;
  logic        pix_valid = 1'b0;
  logic [71:0] win_pix = '0;
  logic        chrom_ready, out_valid;
  logic [7:0]  out_pix;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [3:0] ch [28];

  always #5 clk = ~clk;

  evo_filter3x3 u0 (.clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_nibble(cfg_nibble),
    .pix_valid(pix_valid), .win_pix(win_pix), .chrom_ready(chrom_ready),
    .out_valid(out_valid), .out_pix(out_pix));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int op_model(input int op, input int x, input int y);
    case (op)
      0: return 255;
      1: return x;
      2: return 255 - x;
      3: return x | y;
      4: return ((~x) & 255) | y;
      5: return x & y;
      6: return (~(x & y)) & 255;
      7: return x ^ y;
      8: return x >> 1;
      9: return x >> 2;
      10: return ((x & 15) << 4) | (x >> 4);
      11: return (x + y) & 255;
      12: return (x + y > 255) ? 255 : x + y;
      13: return (x + y) >> 1;
      14: return (x > y) ? x : y;
      default: return (x < y) ? x : y;
    endcase
  endfunction

  function automatic int model(input logic [71:0] w);
    int pe [9];
    int src [2];
    for (int p = 0; p < 9; p++) begin
      for (int k = 0; k < 2; k++) begin
        int s = int'(ch[3*p+k]);
        int col = p / 3;
        if (s <= 8) src[k] = int'(w[s*8 +: 8]);
        else if (s <= 11 && col >= 1) src[k] = pe[s-9];
        else if (s >= 12 && s <= 14 && col >= 2) src[k] = pe[s-9];
        else src[k] = int'(w[7:0]);
      end
      pe[p] = op_model(int'(ch[3*p+2]), src[0], src[1]);
    end
    return pe[(ch[27] > 8) ? 8 : int'(ch[27])];
  endfunction

  function automatic logic [71:0] mkwin(input int b);
    logic [71:0] w;
    for (int k = 0; k < 9; k++) w[k*8 +: 8] = 8'((b + 29 * k) & 255);
    return w;
  endfunction

  task automatic clear_ch();
    for (int i = 0; i < 28; i++) ch[i] = '0;
  endtask

  task automatic load();
    for (int i = 0; i < 28; i++) begin
      @(negedge clk);
      cfg_valid = 1'b1;
      cfg_nibble = ch[i];
    end
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic apply(input string req, input logic [71:0] w);
    @(negedge clk);
    win_pix = w;
    pix_valid = 1'b1;
    @(negedge clk);
    pix_valid = 1'b0;
    chk({req, " out_valid"}, int'(out_valid), 1);
    chk({req, " out_pix"}, int'(out_pix), model(w));
  endtask

  task automatic t_reset();
    chk("R1 ready", int'(chrom_ready), 0);
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 pix", int'(out_pix), 0);
    apply("R1 default genome", mkwin(17));
    chk("R1 default is 255", int'(out_pix), 255);
  endtask

  task automatic t_load_timing();
    clear_ch();
    ch[0] = 4'd4; ch[2] = 4'd1;
    for (int i = 0; i < 27; i++) begin
      @(negedge clk);
      cfg_valid = 1'b1;
      cfg_nibble = ch[i];
    end
    @(negedge clk);
    chk("R2 not ready after 27", int'(chrom_ready), 0);
    cfg_nibble = ch[27];
    @(negedge clk);
    cfg_valid = 1'b0;
    chk("R2 ready after 28", int'(chrom_ready), 1);
    apply("R4 pixel 4 pass-through", mkwin(3));
  endtask

  task automatic t_ops();
    int xs [3] = '{200, 60, 7};
    int ys [3] = '{100, 165, 250};
    for (int op = 0; op < 16; op++) begin
      string req;
      req = (op <= 2 || (op >= 8 && op <= 10)) ? "R6" : ((op <= 7) ? "R7" : "R8");
      clear_ch();
      ch[0] = 4'd3; ch[1] = 4'd5; ch[2] = 4'(op);
      load();
      for (int v = 0; v < 3; v++) begin
        logic [71:0] w = mkwin(v * 11);
        w[3*8 +: 8] = 8'(xs[v]);
        w[5*8 +: 8] = 8'(ys[v]);
        @(negedge clk);
        win_pix = w;
        pix_valid = 1'b1;
        @(negedge clk);
        pix_valid = 1'b0;
        chk($sformatf("%s op %0d", req, op), int'(out_pix), op_model(op, xs[v], ys[v]));
      end
    end
  endtask

  task automatic t_route();
    clear_ch();
    ch[0] = 4'd1; ch[2] = 4'd1;
    ch[12] = 4'd2; ch[14] = 4'd1;
    ch[24] = 4'd9; ch[25] = 4'd13; ch[26] = 4'd11;
    ch[27] = 4'd8;
    load();
    apply("R5 col2 from PE0 and PE4", mkwin(40));
    chk("R5 sum value", int'(out_pix), (29 + 40 + 58 + 40) & 255);
  endtask

  task automatic t_backward();
    clear_ch();
    ch[9] = 4'd12; ch[11] = 4'd1;
    ch[21] = 4'd15; ch[23] = 4'd1;
    ch[6] = 4'd9; ch[8] = 4'd1;
    ch[27] = 4'd3;
    load();
    apply("R5 col1 selects col1 -> centre", mkwin(77));
    chk("R5 centre value", int'(out_pix), 77);
    ch[27] = 4'd7;
    load();
    apply("R5 select 15 -> centre", mkwin(91));
    chk("R5 centre value 15", int'(out_pix), 91);
    ch[27] = 4'd2;
    load();
    apply("R5 col0 selects PE -> centre", mkwin(123));
    chk("R5 centre value col0", int'(out_pix), 123);
  endtask

  task automatic t_outsel();
    clear_ch();
    for (int p = 0; p < 9; p++) begin
      ch[3*p] = 4'(p);
      ch[3*p+2] = 4'd1;
    end
    ch[27] = 4'd5;
    load();
    apply("R9 select PE5", mkwin(10));
    ch[27] = 4'd12;
    load();
    apply("R9 select 12 -> PE8", mkwin(10));
    chk("R9 value PE8", int'(out_pix), (10 + 29 * 8) & 255);
  endtask

  task automatic t_reload();
    @(negedge clk);
    chk("R3 ready before", int'(chrom_ready), 1);
    cfg_valid = 1'b1;
    cfg_nibble = 4'd0;
    @(negedge clk);
    cfg_valid = 1'b0;
    chk("R3 ready dropped", int'(chrom_ready), 0);
    clear_ch();
    ch[0] = 4'd6; ch[2] = 4'd2;
    for (int i = 1; i < 28; i++) begin
      @(negedge clk);
      cfg_valid = 1'b1;
      cfg_nibble = ch[i];
    end
    @(negedge clk);
    cfg_valid = 1'b0;
    chk("R3 ready after fresh load", int'(chrom_ready), 1);
    ch[0] = 4'd0;
    apply("R3 restarted at nibble 0", mkwin(50));
  endtask

  task automatic t_hold();
    int keep;
    apply("R10 capture", mkwin(5));
    keep = int'(out_pix);
    @(negedge clk);
    win_pix = mkwin(200);
    chk("R10 valid low", int'(out_valid), 0);
    @(negedge clk);
    @(negedge clk);
    chk("R10 hold", int'(out_pix), keep);
  endtask

  initial begin
    clear_ch();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_timing();
    t_ops();
    t_route();
    t_backward();
    t_outsel();
    t_reload();
    t_hold();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule